// File: doc/BRIEF.md
# Compare/Capture Counter Array

The block is a timing peripheral built around one shared 16-bit up-counter and five identical channels. Each channel has a mode byte, a 16-bit compare/capture register and one pin in each direction. A channel can capture the counter on a pin edge. It can raise a flag when the counter reaches a programmed value. It can toggle its output pin on that match. It can also produce an 8-bit pulse-width-modulated waveform with a double-buffered duty value.

Software programs the block with byte writes to a small address space. Address 0 is the control byte. Addresses 1 and 2 are the low and high counter bytes. Address 3 clears flags. Channel k uses address 8+4k for its mode byte, 8+4k+1 for the low compare byte and 8+4k+2 for the high compare byte. The counter state, the flags, the channel pins and the compare/capture registers are brought out as outputs.

Top module: `cca_top`

## Requirements
- R1: After reset the counter, the overflow flag, every channel flag, every compare/capture register and every channel output pin are zero.
- R2: Control byte bits [3:2] select the count source: 0 steps once every 6 clocks, 1 once every 2 clocks, 2 once per clock in which `t0_ovf_i` is high, and 3 once per rising edge of `ext_cnt_i` after a two-stage synchronizer. Writes to addresses 1 and 2 load the counter bytes directly.
- R3: The counter advances only while control bit 0 (run) is 1. When control bit 1 (freeze-in-idle) is 1 and `idle_i` is high, the counter holds its value.
- R4: A step from FFFFh to 0000h sets `ovf_flag_o` on the same edge. Writing 1 to bit 7 of address 3 clears it.
- R5: A write to a channel's low compare byte clears that channel's arm bit (mode bit 6). A write to its high compare byte sets the arm bit. A channel that is not armed produces no match.
- R6: With mode bits 6 (arm) and 3 (match) set and bit 2 clear, a counter step onto the compare value sets the channel flag one clock later and leaves the pin unchanged.
- R7: With mode bits 6, 3 and 2 (toggle) set, a counter step onto the compare value inverts the channel pin and sets its flag one clock later.
- R8: Mode bit 5 selects capture on rising pin edges and mode bit 4 selects capture on falling edges. A selected edge, seen through a two-stage synchronizer, copies the counter into the compare/capture register and sets the flag. An edge of the other polarity changes nothing.
- R9: With mode bits 6 and 1 (PWM) set, the pin is 0 while the counter low byte is below the low compare byte and 1 otherwise. The high compare byte is copied into the low compare byte on the edge where the counter low byte rolls from FFh to 00h, and not before.
- R10: Writing 1 to bit k of address 3 clears channel flag k. A flag set in the same clock wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| idle_i | input | 1 | System idle indication |
| t0_ovf_i | input | 1 | Single-clock overflow pulse from timer 0 |
| ext_cnt_i | input | 1 | External count pin (asynchronous) |
| cex_i | input | 5 | Channel capture pins (asynchronous) |
| wr_en_i | input | 1 | Byte write strobe |
| wr_addr_i | input | 5 | Byte write address |
| wr_data_i | input | 8 | Byte write data |
| cnt_o | output | 16 | Counter value |
| ovf_flag_o | output | 1 | Counter overflow flag |
| mod_flag_o | output | 5 | Per-channel event flags |
| cex_o | output | 5 | Channel output pins |
| ccr_o | output | 80 | Compare/capture registers, channel k at bits [16k+15:16k] |

## Verification
The bench goes after the disarm/re-arm order of the compare byte writes. A design that armed on the low byte would flag a match while the 16-bit value is only half written, and one that never re-armed would stay silent after the high byte. It steps the counter across the 16-bit wrap and across the low-byte wrap in PWM mode. A design that copied the buffered duty value at the write, or on the wrong wrap, would switch the pin at the wrong counter value. It also presents capture edges of the unselected polarity, which a design with swapped polarity bits would latch. Finally it holds the counter still at a matching value after re-arming, which a level-sensitive comparator would flag repeatedly.

// File: rtl/cca_pkg.sv
// Package: shared constants for the compare/capture counter array.
// Assumes byte-wide writes and a 16-bit counter split into two bytes.
package cca_pkg;
    localparam int CNT_W   = 16;
    localparam int BYTE_W  = 8;

    // Fixed address map (block-level addresses)
    localparam int A_CTRL   = 0;
    localparam int A_CNT_LO = 1;
    localparam int A_CNT_HI = 2;
    localparam int A_CLR    = 3;
    localparam int A_CH0    = 8;
    localparam int CH_STRIDE = 4;

    // Mode byte bit positions
    localparam int M_ARM    = 6;
    localparam int M_CAPR   = 5;
    localparam int M_CAPF   = 4;
    localparam int M_MATCH  = 3;
    localparam int M_TOGGLE = 2;
    localparam int M_PWM    = 1;

    // Control byte bit positions
    localparam int C_RUN    = 0;
    localparam int C_FREEZE = 1;
    localparam int C_SEL_LO = 2;

    // Flag clear byte: overflow clear bit
    localparam int CLR_OVF  = 7;

    typedef enum logic [1:0] {
        SRC_DIV_SLOW = 2'd0,
        SRC_DIV_FAST = 2'd1,
        SRC_T0_OVF   = 2'd2,
        SRC_EXT_PIN  = 2'd3
    } cnt_src_e;
endpackage

// File: rtl/cca_sync.sv
// Module: two-stage synchronizer with a third stage for edge detection.
// Assumes the input is asynchronous and held at least two clocks per level.
module cca_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES:0] pipe_q;

    // Shift the asynchronous input through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-1:0], async_i};
    end

    assign level_o = pipe_q[STAGES-1];
    assign rise_o  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    assign fall_o  = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/cca_timebase.sv
// Module: shared counter, its prescaler, source select, run/idle gating and
// overflow flag. Assumes DIV_SLOW is even so that bit 0 of the prescaler
// provides the divide-by-2 step.
module cca_timebase
    import cca_pkg::*;
#(
    parameter int DIV_SLOW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle_i,
    input  logic              t0_ovf_i,
    input  logic              ext_rise_i,
    input  logic              wr_ctrl_i,
    input  logic              wr_lo_i,
    input  logic              wr_hi_i,
    input  logic              ovf_clr_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              step_o,
    output logic              step_d_o,
    output logic              lo_wrap_o,
    output logic              ovf_flag_o
);
    localparam int PRE_W = $clog2(DIV_SLOW);

    logic [PRE_W-1:0]  pre_q;
    logic [3:0]        ctrl_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              step_d_q;
    logic              ovf_q;
    logic              src_step;
    logic              enabled;
    cnt_src_e          src;

    assign src     = cnt_src_e'(ctrl_q[C_SEL_LO +: 2]);
    assign enabled = ctrl_q[C_RUN] & ~(ctrl_q[C_FREEZE] & idle_i);

    // Free-running prescaler for the two internal rates
    always_ff @(posedge clk) begin
        if (!rst_n)                           pre_q <= '0;
        else if (pre_q == PRE_W'(DIV_SLOW-1)) pre_q <= '0;
        else                                  pre_q <= pre_q + 1'b1;
    end

    // Pick the step request of the selected source
    always_comb begin
        unique case (src)
            SRC_DIV_SLOW: src_step = (pre_q == PRE_W'(DIV_SLOW-1));
            SRC_DIV_FAST: src_step = pre_q[0];
            SRC_T0_OVF:   src_step = t0_ovf_i;
            default:      src_step = ext_rise_i;
        endcase
    end

    assign step_o    = src_step & enabled;
    assign lo_wrap_o = step_o & (cnt_q[BYTE_W-1:0] == '1);

    // Control byte register
    always_ff @(posedge clk) begin
        if (!rst_n)         ctrl_q <= '0;
        else if (wr_ctrl_i) ctrl_q <= wr_data_i[3:0];
    end

    // Counter: byte writes override stepping
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (wr_lo_i) cnt_q <= {cnt_q[CNT_W-1:BYTE_W], wr_data_i};
        else if (wr_hi_i) cnt_q <= {wr_data_i, cnt_q[BYTE_W-1:0]};
        else if (step_o)  cnt_q <= cnt_q + 1'b1;
    end

    // Mark the clock after a step so channels compare the new value once
    always_ff @(posedge clk) begin
        if (!rst_n) step_d_q <= 1'b0;
        else        step_d_q <= step_o & ~wr_lo_i & ~wr_hi_i;
    end

    // Overflow flag: set on wrap, cleared by software, set wins
    always_ff @(posedge clk) begin
        if (!rst_n)                                       ovf_q <= 1'b0;
        else if (step_o && !wr_lo_i && !wr_hi_i && cnt_q == '1) ovf_q <= 1'b1;
        else if (ovf_clr_i)                               ovf_q <= 1'b0;
    end

    assign cnt_o      = cnt_q;
    assign step_d_o   = step_d_q;
    assign ovf_flag_o = ovf_q;

    // R4
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o && !wr_lo_i && !wr_hi_i && cnt_q == '1) |=> (ovf_q && cnt_q == '0));

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[C_RUN] && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_q));
endmodule

// File: rtl/cca_channel.sv
// Module: one compare/capture channel. Holds the mode byte and the 16-bit
// compare/capture register, and implements capture, match, toggle and PWM.
// Assumes step_d_i pulses for one clock after each counter step and
// lo_wrap_i pulses on the step that rolls the low counter byte to zero.
module cca_channel
    import cca_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              step_d_i,
    input  logic              lo_wrap_i,
    input  logic              pin_rise_i,
    input  logic              pin_fall_i,
    input  logic              wr_mode_i,
    input  logic              wr_lo_i,
    input  logic              wr_hi_i,
    input  logic              flag_clr_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    output logic              flag_o,
    output logic              pin_o,
    output logic [CNT_W-1:0]  ccr_o
);
    logic [BYTE_W-1:0] mode_q;
    logic [BYTE_W-1:0] lo_q;
    logic [BYTE_W-1:0] hi_q;
    logic              tog_q;
    logic              flag_q;
    logic              armed;
    logic              pwm_on;
    logic              match_on;
    logic              match_hit;
    logic              cap_hit;

    assign armed     = mode_q[M_ARM];
    assign pwm_on    = armed & mode_q[M_PWM];
    assign match_on  = armed & mode_q[M_MATCH] & ~mode_q[M_PWM];
    assign match_hit = match_on & step_d_i & (cnt_i == {hi_q, lo_q});
    assign cap_hit   = (mode_q[M_CAPR] & pin_rise_i) | (mode_q[M_CAPF] & pin_fall_i);

    // Mode byte; compare byte writes move the arm bit
    always_ff @(posedge clk) begin
        if (!rst_n)         mode_q <= '0;
        else if (wr_mode_i) mode_q <= wr_data_i;
        else if (wr_lo_i)   mode_q[M_ARM] <= 1'b0;
        else if (wr_hi_i)   mode_q[M_ARM] <= 1'b1;
    end

    // Low compare byte: write, capture, or PWM reload from the high byte
    always_ff @(posedge clk) begin
        if (!rst_n)                 lo_q <= '0;
        else if (wr_lo_i)           lo_q <= wr_data_i;
        else if (cap_hit)           lo_q <= cnt_i[BYTE_W-1:0];
        else if (pwm_on && lo_wrap_i) lo_q <= hi_q;
    end

    // High compare byte: write or capture
    always_ff @(posedge clk) begin
        if (!rst_n)       hi_q <= '0;
        else if (wr_hi_i) hi_q <= wr_data_i;
        else if (cap_hit) hi_q <= cnt_i[CNT_W-1:BYTE_W];
    end

    // Output toggle on a match in toggle mode
    always_ff @(posedge clk) begin
        if (!rst_n)                             tog_q <= 1'b0;
        else if (match_hit && mode_q[M_TOGGLE]) tog_q <= ~tog_q;
    end

    // Event flag: set on match or capture, cleared by software, set wins
    always_ff @(posedge clk) begin
        if (!rst_n)                   flag_q <= 1'b0;
        else if (match_hit || cap_hit) flag_q <= 1'b1;
        else if (flag_clr_i)          flag_q <= 1'b0;
    end

    assign pin_o  = pwm_on ? (cnt_i[BYTE_W-1:0] >= lo_q) : tog_q;
    assign flag_o = flag_q;
    assign ccr_o  = {hi_q, lo_q};

    // R5
    lo_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo_i && !wr_mode_i) |=> !mode_q[M_ARM]);

    // R5
    hi_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi_i && !wr_lo_i && !wr_mode_i) |=> mode_q[M_ARM]);

    // R9
    pwm_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_on && lo_wrap_i && !wr_lo_i && !cap_hit) |=> (lo_q == $past(hi_q)));

    // R8
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_hit && !wr_lo_i && !wr_hi_i) |=> (flag_q && ccr_o == $past(cnt_i)));

    // R7
    toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_hit && mode_q[M_TOGGLE]) |=> (tog_q != $past(tog_q)));
endmodule

// File: rtl/cca_top.sv
// Module: compare/capture counter array top. Decodes byte writes, hosts the
// shared timebase and replicates one channel per NMOD.
// Assumes ADDR_W covers A_CH0 + CH_STRIDE*NMOD.
module cca_top
    import cca_pkg::*;
#(
    parameter int NMOD     = 5,
    parameter int ADDR_W   = 5,
    parameter int DIV_SLOW = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  idle_i,
    input  logic                  t0_ovf_i,
    input  logic                  ext_cnt_i,
    input  logic [NMOD-1:0]       cex_i,
    input  logic                  wr_en_i,
    input  logic [ADDR_W-1:0]     wr_addr_i,
    input  logic [BYTE_W-1:0]     wr_data_i,
    output logic [CNT_W-1:0]      cnt_o,
    output logic                  ovf_flag_o,
    output logic [NMOD-1:0]       mod_flag_o,
    output logic [NMOD-1:0]       cex_o,
    output logic [NMOD*CNT_W-1:0] ccr_o
);
    logic ext_rise;
    logic ext_level;
    logic ext_fall;
    logic step;
    logic step_d;
    logic lo_wrap;
    logic wr_ctrl;
    logic wr_clr;

    assign wr_ctrl = wr_en_i && (wr_addr_i == ADDR_W'(A_CTRL));
    assign wr_clr  = wr_en_i && (wr_addr_i == ADDR_W'(A_CLR));

    cca_sync u_ext_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_cnt_i),
        .level_o (ext_level),
        .rise_o  (ext_rise),
        .fall_o  (ext_fall)
    );

    cca_timebase #(.DIV_SLOW(DIV_SLOW)) u_tb (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle_i     (idle_i),
        .t0_ovf_i   (t0_ovf_i),
        .ext_rise_i (ext_rise),
        .wr_ctrl_i  (wr_ctrl),
        .wr_lo_i    (wr_en_i && (wr_addr_i == ADDR_W'(A_CNT_LO))),
        .wr_hi_i    (wr_en_i && (wr_addr_i == ADDR_W'(A_CNT_HI))),
        .ovf_clr_i  (wr_clr && wr_data_i[CLR_OVF]),
        .wr_data_i  (wr_data_i),
        .cnt_o      (cnt_o),
        .step_o     (step),
        .step_d_o   (step_d),
        .lo_wrap_o  (lo_wrap),
        .ovf_flag_o (ovf_flag_o)
    );

    for (genvar k = 0; k < NMOD; k++) begin : g_ch
        localparam int BASE = A_CH0 + CH_STRIDE * k;
        logic pin_lvl;
        logic pin_rise;
        logic pin_fall;

        cca_sync u_pin_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (cex_i[k]),
            .level_o (pin_lvl),
            .rise_o  (pin_rise),
            .fall_o  (pin_fall)
        );

        cca_channel u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .cnt_i      (cnt_o),
            .step_d_i   (step_d),
            .lo_wrap_i  (lo_wrap),
            .pin_rise_i (pin_rise),
            .pin_fall_i (pin_fall),
            .wr_mode_i  (wr_en_i && (wr_addr_i == ADDR_W'(BASE))),
            .wr_lo_i    (wr_en_i && (wr_addr_i == ADDR_W'(BASE + 1))),
            .wr_hi_i    (wr_en_i && (wr_addr_i == ADDR_W'(BASE + 2))),
            .flag_clr_i (wr_clr && wr_data_i[k]),
            .wr_data_i  (wr_data_i),
            .flag_o     (mod_flag_o[k]),
            .pin_o      (cex_o[k]),
            .ccr_o      (ccr_o[k*CNT_W +: CNT_W])
        );
    end

    // R2
    step_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr_en_i) |=> (cnt_o == $past(cnt_o) + 1'b1));

    // R10
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_clr && mod_flag_o != '0) |=> ((mod_flag_o & $past(mod_flag_o)) == $past(mod_flag_o)));
endmodule

// File: tb/cca_top_tb.sv
module cca_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NMOD = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        idle_i = 1'b0;
    logic        t0_ovf_i = 1'b0;
    logic        ext_cnt_i = 1'b0;
    logic [4:0]  cex_i = '0;
    logic        wr_en_i = 1'b0;
    logic [4:0]  wr_addr_i = '0;
    logic [7:0]  wr_data_i = '0;
    logic [15:0] cnt_o;
    logic        ovf_flag_o;
    logic [4:0]  mod_flag_o;
    logic [4:0]  cex_o;
    logic [79:0] ccr_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cca_top u_dut (
        .clk(clk), .rst_n(rst_n), .idle_i(idle_i), .t0_ovf_i(t0_ovf_i),
        .ext_cnt_i(ext_cnt_i), .cex_i(cex_i), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .cnt_o(cnt_o),
        .ovf_flag_o(ovf_flag_o), .mod_flag_o(mod_flag_o), .cex_o(cex_o),
        .ccr_o(ccr_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = 5'(addr); wr_data_i = 8'(data);
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic set_cnt(input int v);
        wr(1, v & 8'hFF);
        wr(2, (v >> 8) & 8'hFF);
    endtask

    // one timer-0 step, then settle one more clock
    task automatic step();
        @(negedge clk); t0_ovf_i = 1'b1;
        @(negedge clk); t0_ovf_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 cnt", 32'(cnt_o), 0);
        check("R1 ovf", 32'(ovf_flag_o), 0);
        check("R1 flags", 32'(mod_flag_o), 0);
        check("R1 pins", 32'(cex_o), 0);
        check("R1 ccr", 32'(ccr_o[31:0] | ccr_o[63:32] | 32'(ccr_o[79:64])), 0);
    endtask

    task automatic t_clksel();
        logic [15:0] c0;
        wr(0, 8'h01); set_cnt(0);
        c0 = cnt_o; wait_clk(60);
        check("R2 div6", 32'(cnt_o - c0), 10);
        wr(0, 8'h05);
        c0 = cnt_o; wait_clk(40);
        check("R2 div2", 32'(cnt_o - c0), 20);
        wr(0, 8'h09); set_cnt(0);
        step(); step(); step();
        check("R2 t0", 32'(cnt_o), 3);
        wr(0, 8'h0D); set_cnt(0);
        for (int i = 0; i < 4; i++) begin
            ext_cnt_i = 1'b1; wait_clk(3);
            ext_cnt_i = 1'b0; wait_clk(3);
        end
        wait_clk(4);
        check("R2 ext", 32'(cnt_o), 4);
    endtask

    task automatic t_idle();
        wr(0, 8'h0B); set_cnt(16'h0100); idle_i = 1'b1;
        step(); step();
        check("R3 frozen", 32'(cnt_o), 16'h0100);
        wr(0, 8'h09);
        step(); step();
        check("R3 idle run", 32'(cnt_o), 16'h0102);
        idle_i = 1'b0;
        wr(0, 8'h08);
        step();
        check("R3 stopped", 32'(cnt_o), 16'h0102);
        wr(0, 8'h09);
    endtask

    task automatic t_ovf();
        set_cnt(16'hFFFE);
        step();
        check("R4 no ovf", 32'(ovf_flag_o), 0);
        step();
        check("R4 wrap cnt", 32'(cnt_o), 0);
        check("R4 ovf set", 32'(ovf_flag_o), 1);
        wr(3, 8'h80);
        check("R4 ovf clr", 32'(ovf_flag_o), 0);
    endtask

    task automatic t_swtimer();
        wr(8, 8'h48); wr(9, 8'h10); wr(10, 8'h00);
        set_cnt(16'h000E);
        step();
        check("R6 early", 32'(mod_flag_o[0]), 0);
        step();
        check("R6 match flag", 32'(mod_flag_o[0]), 1);
        check("R6 pin kept", 32'(cex_o[0]), 0);
        wr(3, 8'h01);
        check("R10 clear", 32'(mod_flag_o[0]), 0);
        wr(9, 8'h12);
        step(); step();
        check("R5 disarmed", 32'(mod_flag_o[0]), 0);
        wr(10, 8'h00);
        wait_clk(2);
        check("R5 no level match", 32'(mod_flag_o[0]), 0);
        set_cnt(16'h0011);
        step();
        check("R5 rearmed", 32'(mod_flag_o[0]), 1);
        wr(3, 8'h01);
    endtask

    task automatic t_hso();
        wr(12, 8'h4C); wr(13, 8'h20); wr(14, 8'h00);
        set_cnt(16'h001F);
        step();
        check("R7 pin toggled", 32'(cex_o[1]), 1);
        check("R7 flag", 32'(mod_flag_o[1]), 1);
        wr(3, 8'h02);
        set_cnt(16'h001F);
        step();
        check("R7 pin back", 32'(cex_o[1]), 0);
        wr(3, 8'h02);
    endtask

    task automatic t_capture();
        wr(16, 8'h20); set_cnt(16'h1234);
        cex_i[2] = 1'b1; wait_clk(4);
        check("R8 rise value", 32'(ccr_o[47:32]), 16'h1234);
        check("R8 rise flag", 32'(mod_flag_o[2]), 1);
        wr(3, 8'h04);
        set_cnt(16'h2222);
        cex_i[2] = 1'b0; wait_clk(4);
        check("R8 fall ignored", 32'(ccr_o[47:32]), 16'h1234);
        check("R8 fall no flag", 32'(mod_flag_o[2]), 0);
        wr(16, 8'h10); set_cnt(16'h3333);
        cex_i[2] = 1'b1; wait_clk(4);
        check("R8 rise ignored", 32'(ccr_o[47:32]), 16'h1234);
        cex_i[2] = 1'b0; wait_clk(4);
        check("R8 fall value", 32'(ccr_o[47:32]), 16'h3333);
        wr(3, 8'h04);
    endtask

    task automatic t_pwm();
        wr(20, 8'h42); wr(21, 8'h80); wr(22, 8'h80);
        set_cnt(16'h007F); wait_clk(1);
        check("R9 below", 32'(cex_o[3]), 0);
        step();
        check("R9 equal", 32'(cex_o[3]), 1);
        wr(22, 8'h40);
        check("R9 no early load", 32'(ccr_o[55:48]), 8'h80);
        set_cnt(16'h00FE);
        step();
        check("R9 high at FF", 32'(cex_o[3]), 1);
        step();
        check("R9 reload", 32'(ccr_o[55:48]), 8'h40);
        check("R9 low after wrap", 32'(cex_o[3]), 0);
        set_cnt(16'h013F);
        step();
        check("R9 new duty", 32'(cex_o[3]), 1);
    endtask

    initial begin
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(1);
        t_reset();
        t_clksel();
        t_idle();
        t_ovf();
        t_swtimer();
        t_hso();
        t_capture();
        t_pwm();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule